// File: doc/BRIEF.md
# AES3 Biphase Frame Encoder

This block turns a stream of audio samples into one serial digital-audio line signal of the AES3 / S/PDIF kind. Every frame holds two subframes, A and B. Each subframe has 32 time slots: a 4-slot sync preamble, 24 audio bits sent least significant bit first, then the validity, user, channel-status and parity bits. The block biphase-mark codes the subframe onto `bmc_out`. The clock runs at twice the bit-cell rate, so each slot takes two clocks and a subframe takes 64.

The block pulls its inputs. `smp_take` is high for one clock, and at the rising edge that ends that clock the block captures the sample inputs. A 192-frame counter walks through the channel-status block and selects one bit of each channel's 192-bit status vector per frame. When bit 0 of the selected vector marks professional use, the block computes the CRC byte itself. Mono mode carries one audio channel: two successive samples fill A and B of one frame, so the input runs at twice the frame rate. Mode inputs are static; they change only while reset is held.

Top module: `aes3_tx_enc`

## Requirements
- R1: Subframe slot map. Slots 0-3 hold the preamble. Slots 4-27 hold audio bits 0-23, least significant bit first. Slot 28 holds validity, slot 29 user, slot 30 channel status and slot 31 parity. Each slot lasts 2 clocks, subframe A comes before B, and a frame lasts 128 clocks.
- R2: The parity slot makes the number of ones in slots 4-31 even.
- R3: Biphase-mark coding. `bmc_out` toggles at the start of every cell in slots 4-31, and toggles again mid-cell when the bit is 1. `bmc_out` is 0 in reset. The first half-cell of frame 0 subframe A appears on the output during the second clock after reset is released.
- R4: The preamble uses eight half-cells, written first half first, for a preceding level of 0: 11101000 on subframe A of block frame 0, 11100010 on every other subframe A, and 11100100 on subframe B. All eight half-cells are inverted when the preceding level is 1.
- R5: The frame counter runs from 0 to 191, starts at 0 after reset and advances at the end of each frame. `blk_start` is high while frame 0 is being formed and is 1 in reset.
- R6: When `blk_ext` is 1, a frame end at which `blk_in` is 1 makes the next frame frame 0.
- R7: In stereo, `smp_take` pulses once per frame, in the last clock of subframe B. That edge loads the left inputs for subframe A and the right inputs for subframe B of the next frame. The first frame after reset carries zero audio, validity and user bits.
- R8: In mono, `smp_take` pulses in the last clock of every subframe and the left inputs are loaded each time. The sample taken at the end of A goes out in B of the same frame, and the sample taken at the end of B goes out in A of the next frame.
- R9: Frame n carries bit n of a status vector. With `cs_shared`=0, A uses `cs_a` and B uses `cs_b`. With `cs_shared`=1, both subframes use `cs_b` if `cs_use_b`=1 and `cs_a` otherwise.
- R10: If bit 0 of a subframe's selected vector is 1, frames 184+k (k = 0 to 7) carry bit k of a CRC instead of the vector bit. The CRC register starts at 0xFF at frame 0. For each of bits 0-183 in order it updates as c = (c<<1) ^ ((b ^ c[7]) ? 0x1D : 0).
- R11: While `mute` is 1, the audio slots carry zeros and parity follows the zeroed audio. Framing, validity, user and channel status are unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Half-cell clock, two clocks per slot |
| rst_n | input | 1 | Synchronous active-low reset |
| mono_en | input | 1 | 1 = mono mode |
| cs_shared | input | 1 | 1 = both subframes use one status vector |
| cs_use_b | input | 1 | Shared mode: 1 = use `cs_b`, 0 = use `cs_a` |
| mute | input | 1 | 1 = send zero audio |
| blk_ext | input | 1 | 1 = `blk_in` may restart the block |
| blk_in | input | 1 | External block restart request, sampled at frame end |
| aud_l | input | 24 | Left (or mono) sample |
| aud_r | input | 24 | Right sample |
| val_l | input | 1 | Left validity bit |
| val_r | input | 1 | Right validity bit |
| usr_l | input | 1 | Left user bit |
| usr_r | input | 1 | Right user bit |
| cs_a | input | 192 | Channel status block for subframe A |
| cs_b | input | 192 | Channel status block for subframe B |
| smp_take | output | 1 | Inputs are captured at the edge that ends this clock |
| blk_start | output | 1 | High while frame 0 is being formed |
| bmc_out | output | 1 | Biphase-mark line signal |

## Verification
The bench builds the block with the default 192-frame block, so stereo and mono runs each cross a whole block boundary. That makes every frame index reachable, including the CRC frames 184-191, the wrap back to the block-start preamble, and a restart forced by `blk_in` partway through a block. Separate and shared status selection, mute, and both take patterns are each run in their own reset phase.

// File: rtl/aes3_tx_pkg.sv
// Shared constants, types and helper functions for the AES3 encoder.
// Assumes the fixed 32-slot subframe layout; only the block length is a parameter.
package aes3_tx_pkg;
    localparam int SUB_HALVES     = 64;
    localparam int POS_W          = $clog2(SUB_HALVES);
    localparam int SLOT_W         = POS_W - 1;
    localparam int PRE_HALVES     = 8;
    localparam int AUD_W          = 24;
    localparam int FIRST_AUD_SLOT = 4;
    localparam int V_SLOT         = FIRST_AUD_SLOT + AUD_W;
    localparam int U_SLOT         = V_SLOT + 1;
    localparam int C_SLOT         = U_SLOT + 1;
    localparam int P_SLOT         = C_SLOT + 1;
    localparam int CRC_BITS       = 8;
    localparam logic [CRC_BITS-1:0] CRC_POLY = 8'h1D;
    localparam logic [CRC_BITS-1:0] CRC_INIT = 8'hFF;

    typedef enum logic [1:0] {
        PRE_Z = 2'd0,   // block start, subframe A
        PRE_X = 2'd1,   // other subframe A
        PRE_Y = 2'd2    // subframe B
    } pre_kind_t;

    // Half-cell levels of a preamble, first half in bit 7, for a prior level of 0.
    function automatic logic [PRE_HALVES-1:0] pre_levels(input pre_kind_t k);
        case (k)
            PRE_Z:   return 8'b1110_1000;
            PRE_X:   return 8'b1110_0010;
            default: return 8'b1110_0100;
        endcase
    endfunction

    // One bit-serial step of the channel-status CRC.
    function automatic logic [CRC_BITS-1:0] crc_step(input logic [CRC_BITS-1:0] c,
                                                     input logic b);
        logic fb;
        fb = b ^ c[CRC_BITS-1];
        return {c[CRC_BITS-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
    endfunction
endpackage

// File: rtl/aes3_tx_timer.sv
// Half-cell position, subframe and block-frame counter, plus the sample pull strobe.
// Assumes BLK_FRAMES >= 9, so that the CRC frames fit after frame 0.
module aes3_tx_timer
    import aes3_tx_pkg::*;
#(
    parameter int BLK_FRAMES = 192,
    localparam int FRM_W = $clog2(BLK_FRAMES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mono_en,
    input  logic             blk_ext,
    input  logic             blk_in,
    output logic [POS_W-1:0] pos,
    output logic             sub,
    output logic [FRM_W-1:0] frame,
    output logic             take,
    output logic             wrap
);
    localparam logic [FRM_W-1:0] LAST_FRAME = FRM_W'(BLK_FRAMES - 1);
    localparam logic [POS_W-1:0] LAST_POS   = POS_W'(SUB_HALVES - 1);

    logic sub_end;
    logic frame_end;

    // Decode the subframe and frame ends, the take strobe and the block wrap.
    always_comb begin
        sub_end   = (pos == LAST_POS);
        frame_end = sub_end && sub;
        take      = sub_end && (sub || mono_en);                       // R7 R8
        wrap      = frame_end && ((blk_ext && blk_in) || frame == LAST_FRAME); // R5 R6
    end

    // Advance position, subframe and frame counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos   <= '0;
            sub   <= 1'b0;
            frame <= '0;
        end else begin
            pos <= pos + 1'b1;
            if (sub_end) sub <= ~sub;
            if (wrap) frame <= '0;
            else if (frame_end) frame <= frame + 1'b1;
        end
    end
endmodule

// File: rtl/aes3_tx_cs.sv
// Channel-status bit selection and CRC generation for both subframes.
// Assumes the status vectors stay stable over a block.
module aes3_tx_cs
    import aes3_tx_pkg::*;
#(
    parameter int BLK_FRAMES = 192,
    localparam int FRM_W = $clog2(BLK_FRAMES)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [BLK_FRAMES-1:0] cs_a,
    input  logic [BLK_FRAMES-1:0] cs_b,
    input  logic                  cs_shared,
    input  logic                  cs_use_b,
    input  logic                  sub,
    input  logic [POS_W-1:0]      pos,
    input  logic [FRM_W-1:0]      frame,
    input  logic                  wrap,
    output logic                  c_bit,
    output logic [CRC_BITS-1:0]   crc_a,
    output logic [CRC_BITS-1:0]   crc_b
);
    localparam logic [FRM_W-1:0] CRC_FIRST = FRM_W'(BLK_FRAMES - CRC_BITS);
    localparam logic [POS_W-1:0] LAST_POS  = POS_W'(SUB_HALVES - 1);

    logic [BLK_FRAMES-1:0] cur_cs;
    logic [CRC_BITS-1:0]   crc_cur;
    logic                  in_crc;

    // Pick the status vector and the bit for the subframe being formed.
    always_comb begin
        if (cs_shared) cur_cs = cs_use_b ? cs_b : cs_a;              // R9
        else           cur_cs = sub ? cs_b : cs_a;
        crc_cur = sub ? crc_b : crc_a;
        in_crc  = (frame >= CRC_FIRST);
        if (in_crc && cur_cs[0])                                      // R10
            c_bit = crc_cur[3'(frame - CRC_FIRST)];
        else
            c_bit = cur_cs[frame];
    end

    // Fold each sent status bit of frames 0..183 into that subframe's CRC.
    always_ff @(posedge clk) begin
        if (!rst_n || wrap) begin
            crc_a <= CRC_INIT;
            crc_b <= CRC_INIT;
        end else if (pos == LAST_POS && !in_crc) begin
            if (sub) crc_b <= crc_step(crc_b, c_bit);
            else     crc_a <= crc_step(crc_a, c_bit);
        end
    end
endmodule

// File: rtl/aes3_tx_bmc.sv
// Biphase-mark line coder: preamble patterns in the first eight half-cells,
// then a boundary toggle per cell and a mid-cell toggle for each 1.
// Assumes slot_bit is stable over both halves of a slot.
module aes3_tx_bmc
    import aes3_tx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [POS_W-1:0] pos,
    input  pre_kind_t        pre,
    input  logic             slot_bit,
    output logic             bmc_out
);
    logic                  inv_q;
    logic                  inv;
    logic [PRE_HALVES-1:0] pat;
    logic                  nxt;

    // Work out the next half-cell level from the current one.
    always_comb begin
        pat = pre_levels(pre);
        inv = (pos == '0) ? bmc_out : inv_q;
        if (pos < POS_W'(PRE_HALVES))                                 // R4
            nxt = pat[3'd7 - pos[2:0]] ^ inv;
        else if (!pos[0])                                             // R3
            nxt = ~bmc_out;
        else
            nxt = slot_bit ? ~bmc_out : bmc_out;
    end

    // Register the line level and hold the preamble polarity.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bmc_out <= 1'b0;
            inv_q   <= 1'b0;
        end else begin
            bmc_out <= nxt;
            if (pos == '0) inv_q <= bmc_out;
        end
    end
endmodule

// File: rtl/aes3_tx_enc.sv
// AES3 frame encoder top: sample holding, slot multiplexing, parity and mute.
// Assumes mode inputs change only while reset is held.
module aes3_tx_enc
    import aes3_tx_pkg::*;
#(
    parameter int BLK_FRAMES = 192
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  mono_en,
    input  logic                  cs_shared,
    input  logic                  cs_use_b,
    input  logic                  mute,
    input  logic                  blk_ext,
    input  logic                  blk_in,
    input  logic [AUD_W-1:0]      aud_l,
    input  logic [AUD_W-1:0]      aud_r,
    input  logic                  val_l,
    input  logic                  val_r,
    input  logic                  usr_l,
    input  logic                  usr_r,
    input  logic [BLK_FRAMES-1:0] cs_a,
    input  logic [BLK_FRAMES-1:0] cs_b,
    output logic                  smp_take,
    output logic                  blk_start,
    output logic                  bmc_out
);
    localparam int FRM_W = $clog2(BLK_FRAMES);

    logic [POS_W-1:0]    tmr_pos;
    logic                tmr_sub;
    logic [FRM_W-1:0]    tmr_frame;
    logic                tmr_wrap;
    logic                c_bit;
    logic [CRC_BITS-1:0] crc_a_w;
    logic [CRC_BITS-1:0] crc_b_w;

    logic [AUD_W-1:0]    aud_a_q, aud_b_q, aud_cur;
    logic                v_a_q, v_b_q, u_a_q, u_b_q, v_cur, u_cur;
    logic                par;
    logic [SLOT_W-1:0]   slot;
    logic                slot_bit;
    pre_kind_t           pre;

    aes3_tx_timer #(.BLK_FRAMES(BLK_FRAMES)) u_timer (
        .clk(clk), .rst_n(rst_n), .mono_en(mono_en), .blk_ext(blk_ext), .blk_in(blk_in),
        .pos(tmr_pos), .sub(tmr_sub), .frame(tmr_frame), .take(smp_take), .wrap(tmr_wrap)
    );

    aes3_tx_cs #(.BLK_FRAMES(BLK_FRAMES)) u_cs (
        .clk(clk), .rst_n(rst_n), .cs_a(cs_a), .cs_b(cs_b), .cs_shared(cs_shared),
        .cs_use_b(cs_use_b), .sub(tmr_sub), .pos(tmr_pos), .frame(tmr_frame),
        .wrap(tmr_wrap), .c_bit(c_bit), .crc_a(crc_a_w), .crc_b(crc_b_w)
    );

    aes3_tx_bmc u_bmc (
        .clk(clk), .rst_n(rst_n), .pos(tmr_pos), .pre(pre),
        .slot_bit(slot_bit), .bmc_out(bmc_out)
    );

    // Capture samples at each take: both channels in stereo, one slot in mono.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            aud_a_q <= '0; aud_b_q <= '0;
            v_a_q <= 1'b0; v_b_q <= 1'b0; u_a_q <= 1'b0; u_b_q <= 1'b0;
        end else if (smp_take) begin
            if (!mono_en) begin                                       // R7
                aud_a_q <= aud_l; v_a_q <= val_l; u_a_q <= usr_l;
                aud_b_q <= aud_r; v_b_q <= val_r; u_b_q <= usr_r;
            end else if (tmr_sub) begin                               // R8
                aud_a_q <= aud_l; v_a_q <= val_l; u_a_q <= usr_l;
            end else begin
                aud_b_q <= aud_l; v_b_q <= val_l; u_b_q <= usr_l;
            end
        end
    end

    // Select the current subframe's fields, the parity and the preamble kind.
    always_comb begin
        aud_cur   = mute ? '0 : (tmr_sub ? aud_b_q : aud_a_q);        // R11
        v_cur     = tmr_sub ? v_b_q : v_a_q;
        u_cur     = tmr_sub ? u_b_q : u_a_q;
        par       = ^{aud_cur, v_cur, u_cur, c_bit};                  // R2
        blk_start = (tmr_frame == '0);                                // R5
        if (tmr_sub)        pre = PRE_Y;
        else if (blk_start) pre = PRE_Z;
        else                pre = PRE_X;
    end

    // Multiplex the bit for the current slot.
    always_comb begin
        slot     = tmr_pos[POS_W-1:1];
        slot_bit = 1'b0;
        if (slot >= SLOT_W'(FIRST_AUD_SLOT) && slot < SLOT_W'(V_SLOT))  // R1
            slot_bit = aud_cur[5'(slot - SLOT_W'(FIRST_AUD_SLOT))];
        else if (slot == SLOT_W'(V_SLOT)) slot_bit = v_cur;
        else if (slot == SLOT_W'(U_SLOT)) slot_bit = u_cur;
        else if (slot == SLOT_W'(C_SLOT)) slot_bit = c_bit;
        else if (slot == SLOT_W'(P_SLOT)) slot_bit = par;
    end
endmodule

// File: rtl/aes3_tx_enc_chk.sv
// Property checker for the AES3 encoder, bound into the top module.
module aes3_tx_enc_chk
    import aes3_tx_pkg::*;
#(
    parameter int BLK_FRAMES = 192,
    localparam int FRM_W = $clog2(BLK_FRAMES)
) (
    input logic                clk,
    input logic                rst_n,
    input logic                mono_en,
    input logic                smp_take,
    input logic                bmc_out,
    input logic [POS_W-1:0]    pos,
    input logic                sub,
    input logic [FRM_W-1:0]    frame,
    input logic [CRC_BITS-1:0] crc_a,
    input logic [CRC_BITS-1:0] crc_b
);
    localparam logic [FRM_W-1:0] CRC_FIRST = FRM_W'(BLK_FRAMES - CRC_BITS);

    AST_CELL_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (pos[0] && pos >= POS_W'(PRE_HALVES + 1)) |-> (bmc_out != $past(bmc_out))); // R3

    AST_FRAME_AT_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(frame) |-> $past(smp_take)); // R5

    AST_TAKE_SUB_TURN: assert property (@(posedge clk) disable iff (!rst_n)
        smp_take |=> !$stable(sub)); // R7

    AST_MONO_EVERY_SUB: assert property (@(posedge clk) disable iff (!rst_n)
        (mono_en && pos == '0 && $past(pos) == POS_W'(SUB_HALVES - 1)) |-> $past(smp_take)); // R8

    AST_CRC_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (frame >= CRC_FIRST && $past(frame) >= CRC_FIRST) |-> ($stable(crc_a) && $stable(crc_b))); // R10
endmodule

bind aes3_tx_enc aes3_tx_enc_chk #(.BLK_FRAMES(BLK_FRAMES)) u_chk (
    .clk(clk), .rst_n(rst_n), .mono_en(mono_en), .smp_take(smp_take), .bmc_out(bmc_out),
    .pos(tmr_pos), .sub(tmr_sub), .frame(tmr_frame), .crc_a(crc_a_w), .crc_b(crc_b_w)
);

// File: tb/aes3_tx_enc_bench.sv
// Scoreboard bench: the driver answers each take with new samples and queues the
// expected subframes; the monitor decodes the line signal and compares.
module aes3_tx_enc_bench;
    localparam int BLK = 192;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst_n = 1'b0;
    logic mono_en = 0, cs_shared = 0, cs_use_b = 0, mute = 0, blk_ext = 0, blk_in = 0;
    logic [23:0] aud_l = '0, aud_r = '0;
    logic val_l = 0, val_r = 0, usr_l = 0, usr_r = 0;
    logic [BLK-1:0] cs_a = '0, cs_b = '0;
    logic smp_take, blk_start, bmc_out;

    aes3_tx_enc #(.BLK_FRAMES(BLK)) u_aes3_tx_enc (
        .clk(clk), .rst_n(rst_n), .mono_en(mono_en), .cs_shared(cs_shared),
        .cs_use_b(cs_use_b), .mute(mute), .blk_ext(blk_ext), .blk_in(blk_in),
        .aud_l(aud_l), .aud_r(aud_r), .val_l(val_l), .val_r(val_r),
        .usr_l(usr_l), .usr_r(usr_r), .cs_a(cs_a), .cs_b(cs_b),
        .smp_take(smp_take), .blk_start(blk_start), .bmc_out(bmc_out)
    );

    typedef struct {
        int          frame;
        logic [1:0]  pre;
        logic [23:0] aud;
        logic        v, u, c;
    } exp_t;

    exp_t  q[$];
    int    n_chk = 0, n_err = 0;
    bit    done = 0;
    logic  mon_en = 0, draining = 0;
    int    idx = 0;
    logic  [63:0] halves;
    logic  prev_lvl = 0;
    string aud_tag = "R1", blk_tag = "R5";

    task automatic check(input bit ok, input string tag, input longint act, input longint expv);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    function automatic logic [7:0] crc_of(input logic [BLK-1:0] v);
        logic [7:0] c = 8'hFF;
        for (int i = 0; i < BLK - 8; i++)
            c = {c[6:0], 1'b0} ^ ((v[i] ^ c[7]) ? 8'h1D : 8'h00);
        return c;
    endfunction

    function automatic logic c_of(input int frame, input logic sb);
        logic [BLK-1:0] sel;
        logic [7:0] crc;
        if (cs_shared) sel = cs_use_b ? cs_b : cs_a;
        else           sel = sb ? cs_b : cs_a;
        if (frame >= BLK - 8 && sel[0]) begin
            crc = crc_of(sel);
            return crc[frame - (BLK - 8)];
        end
        return sel[frame];
    endfunction

    function automatic logic [7:0] pat_of(input logic [1:0] k);
        case (k)
            2'd0:    return 8'hE8;
            2'd1:    return 8'hE2;
            default: return 8'hE4;
        endcase
    endfunction

    task automatic push(input int frame, input logic sb, input logic [23:0] a,
                        input logic v, input logic u);
        exp_t e;
        e.frame = frame;
        e.pre   = sb ? 2'd2 : (frame == 0 ? 2'd0 : 2'd1);
        e.aud   = mute ? 24'd0 : a;
        e.v     = v;
        e.u     = u;
        e.c     = c_of(frame, sb);
        q.push_back(e);
    endtask

    // Monitor: gather 64 half-cells per subframe, decode and compare.
    always @(negedge clk) begin
        if (mon_en) begin
            halves[idx] = bmc_out;
            if (idx == 0) begin
                if (q.size() == 0) check(0, "R1 no subframe expected", 1, 0);
                else check(blk_start == (q[0].frame == 0), blk_tag, blk_start, q[0].frame == 0);
            end
            if (idx == 63) begin
                idx = 0;
                if (q.size() == 0) begin
                    check(0, "R1 extra subframe", 1, 0);
                end else begin
                    exp_t e;
                    logic [7:0]  pg;
                    logic [31:0] sb;
                    bit bd_ok;
                    e = q.pop_front();
                    for (int i = 0; i < 8; i++) pg[7 - i] = halves[i] ^ prev_lvl;
                    check(pg == pat_of(e.pre), "R4 preamble", pg, pat_of(e.pre));
                    bd_ok = 1;
                    sb = '0;
                    for (int k = 4; k < 32; k++) begin
                        if (halves[2*k] == halves[2*k - 1]) bd_ok = 0;
                        sb[k] = halves[2*k] ^ halves[2*k + 1];
                    end
                    check(bd_ok, "R3 cell boundary toggle", bd_ok, 1);
                    check((^sb[31:4]) == 1'b0, "R2 even parity", ^sb[31:4], 0);
                    check(sb[27:4] == e.aud, aud_tag, sb[27:4], e.aud);
                    check({sb[28], sb[29]} == {e.v, e.u}, "R1 validity and user", {sb[28], sb[29]}, {e.v, e.u});
                    check(sb[30] == e.c, $sformatf("R9 R10 status bit frame %0d", e.frame), sb[30], e.c);
                end
                prev_lvl = halves[63];
                if (draining && q.size() == 0) mon_en = 0;
            end else begin
                idx++;
            end
        end
    end

    task automatic run_phase(input bit mono, input bit shared, input bit useb, input bit mut,
                             input bit ext, input int takes, input int restart_at,
                             input string atag, input string btag);
        int df;
        logic ds;
        int n;
        @(negedge clk);
        rst_n = 0; mon_en = 0; draining = 0; q.delete();
        mono_en = mono; cs_shared = shared; cs_use_b = useb; mute = mut; blk_ext = ext; blk_in = 0;
        aud_l = '0; aud_r = '0; val_l = 0; val_r = 0; usr_l = 0; usr_r = 0;
        repeat (3) @(negedge clk);
        check(bmc_out == 1'b0, "R3 reset line level", bmc_out, 0);
        check(blk_start == 1'b1, "R5 reset at frame 0", blk_start, 1);
        check(smp_take == 1'b0, "R7 no take in reset", smp_take, 0);
        aud_tag = atag; blk_tag = btag;
        push(0, 1'b0, 24'd0, 1'b0, 1'b0);               // R7 first frame zero
        if (!mono) push(0, 1'b1, 24'd0, 1'b0, 1'b0);
        df = mono ? 0 : 1;
        ds = mono ? 1'b1 : 1'b0;
        idx = 0; prev_lvl = 0;
        rst_n = 1;
        @(posedge clk);
        mon_en = 1;
        n = 0;
        while (n < takes) begin
            @(negedge clk);
            if (smp_take) begin
                n++;
                aud_l = 24'($urandom); aud_r = 24'($urandom);
                val_l = 1'($urandom); val_r = 1'($urandom);
                usr_l = 1'($urandom); usr_r = 1'($urandom);
                if (mono) begin
                    push(df, ds, aud_l, val_l, usr_l);         // R8
                    if (ds) begin ds = 1'b0; df = (df == BLK - 1) ? 0 : df + 1; end
                    else ds = 1'b1;
                end else begin
                    blk_in = ext && (n == restart_at);          // R6
                    if (blk_in) df = 0;
                    push(df, 1'b0, aud_l, val_l, usr_l);
                    push(df, 1'b1, aud_r, val_r, usr_r);
                    df = (df == BLK - 1) ? 0 : df + 1;
                end
            end
        end
        draining = 1;
        for (int w = 0; w < 400 && mon_en; w++) @(negedge clk);
        check(!mon_en, "R1 all expected subframes sent", mon_en, 0);
        blk_in = 0;
    endtask

    initial begin
        cs_a = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
        cs_b = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
        cs_a[0] = 1'b1; cs_b[0] = 1'b0;
        // Stereo, separate status, A professional with CRC: R7 R9 R10
        run_phase(0, 0, 0, 0, 0, 200, -1, "R1 R7 stereo audio", "R5 block start");
        // Mono, shared status from B, B professional: R8 R9 R10
        cs_b[0] = 1'b1;
        run_phase(1, 1, 1, 0, 0, 400, -1, "R8 mono audio", "R5 block start");
        // Mute, shared status from A, non-professional: R11
        cs_a[0] = 1'b0;
        run_phase(0, 1, 0, 1, 0, 20, -1, "R11 muted audio", "R5 block start");
        // External block restart: R6
        run_phase(0, 0, 0, 0, 1, 24, 10, "R1 audio", "R6 restart block start");
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog R1 actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule